// File: doc/BRIEF.md
# Eight-Lamp Pattern Sequencer

This block drives a row of eight lamps through four fixed light shows. Each show is a short list of frames, and each frame stays on the lamps for a whole number of seconds. When the last frame of a show has run, the next show starts. After the fourth show, the first show starts again. No trigger from outside is needed: once reset is released, the rotation runs forever.

A 2-bit select sets how long each frame is held: one, two, three or four seconds. The block counts seconds as a fixed number of clock cycles, set by a parameter. Its default of 500 suits a 500 Hz clock. The select is sampled only when a frame is loaded, so a change never shortens or stretches the frame that is already showing. Two status outputs report the show and the frame on display.

Top module: `lamp_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `lamps` = 0x00, `patIdx` = 0 and `frmIdx` = 0.
- R2: On the first clock edge after `rst` goes low, `lamps` becomes 0x01. This is frame 0 of show 0.
- R3: Show 0 has 17 frames. Frames 0 to 7 light only bit f (bit 0 is the rightmost lamp). Frames 8 to 14 light only bit 14-f. Frame 15 is 0x00 and frame 16 is 0xFF.
- R4: Show 1 has 7 frames: 0x81, 0x42, 0x24, 0x18, 0x24, 0x42, 0x81.
- R5: Show 2 has 5 frames: 0xC3, 0x66, 0x3C, 0x66, 0xC3.
- R6: Show 3 has 4 frames: 0xE7, 0xF0, 0x0F, 0x55.
- R7: After the last frame of a show, `patIdx` goes up by one and `frmIdx` returns to 0. After show 3 comes show 0.
- R8: Each frame is held for exactly CYC_PER_SEC × (`dwellSel`+1) cycles. `dwellSel` 00 selects one second and 11 selects four seconds.
- R9: A change of `dwellSel` in the middle of a frame leaves that frame's length unchanged. The new value sets the length of the next frame.
- R10: `patIdx` and `frmIdx` always name the frame that is on the lamps. Within a show, `frmIdx` only counts up by one from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (one second = CYC_PER_SEC cycles) |
| rst | input | 1 | Synchronous reset, active high |
| dwellSel | input | 2 | Frame hold time, in seconds minus one |
| lamps | output | 8 | Lamp vector, 1 = lit, bit 0 = rightmost lamp |
| patIdx | output | 2 | Show currently running (0 to 3) |
| frmIdx | output | 5 | Frame within the show |

## Verification
The bench builds the block with CYC_PER_SEC = 3. This makes one second three cycles long. A full rotation of 33 frames then finishes in about a hundred cycles, and every frame of every show can be compared against a table. The same short second makes all four hold times easy to measure exactly, down to the cycle. It also makes it easy to change the select in the middle of a frame and check where the new value first takes effect.

// File: rtl/lamp_seq_pkg.sv
package lamp_seq_pkg;
  localparam int LAMP_N = 8;
  localparam int PAT_N  = 4;
  localparam int PAT_W  = $clog2(PAT_N);
  localparam int FRM_W  = 5;

  typedef struct packed {
    logic load;   // show the current indices' frame (first frame after reset)
    logic step;   // move to the following frame
  } seqStrobe_t;

  function automatic logic [FRM_W-1:0] frameCount(input logic [PAT_W-1:0] pat);
    case (pat)
      2'd0:    return FRM_W'(17);
      2'd1:    return FRM_W'(7);
      2'd2:    return FRM_W'(5);
      default: return FRM_W'(4);
    endcase
  endfunction

  function automatic logic [LAMP_N-1:0] frameBits(input logic [PAT_W-1:0] pat,
                                                   input logic [FRM_W-1:0] frm);
    int k;
    logic [LAMP_N-1:0] b;
    k = int'(frm);
    case (pat)
      2'd0: begin
        if (k < 8)        b = 8'h01 << k;
        else if (k < 15)  b = 8'h01 << (14 - k);
        else if (k == 15) b = 8'h00;
        else              b = 8'hFF;
      end
      2'd1: begin
        if (k > 3) k = 6 - k;
        b = (8'h80 >> k) | (8'h01 << k);
      end
      2'd2: begin
        if (k > 2) k = 4 - k;
        b = (8'hC0 >> k) | (8'h03 << k);
      end
      default: begin
        case (k)
          0:       b = 8'hE7;
          1:       b = 8'hF0;
          2:       b = 8'h0F;
          default: b = 8'h55;
        endcase
      end
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lamp_seq_ctrl.sv
module lamp_seq_ctrl
  import lamp_seq_pkg::*;
#(
  parameter int CYC_PER_SEC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dwellSel,
  output seqStrobe_t strb
);
  localparam int CNT_W = $clog2(4 * CYC_PER_SEC + 1);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] newLimit;
  logic             frameEnd;

  always_comb begin
    newLimit = CNT_W'(CYC_PER_SEC * (int'(dwellSel) + 1));
    frameEnd = running && (cnt == limit - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      limit   <= '0;
    end else if (!running || frameEnd) begin
      running <= 1'b1;
      cnt     <= '0;
      limit   <= newLimit;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign strb.load = !running;
  assign strb.step = frameEnd;
endmodule

// File: rtl/lamp_seq_path.sv
module lamp_seq_path
  import lamp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strb,
  output logic [LAMP_N-1:0] lamps,
  output logic [PAT_W-1:0]  patIdx,
  output logic [FRM_W-1:0]  frmIdx
);
  logic             lastFrm;
  logic [PAT_W-1:0] nextPat;
  logic [FRM_W-1:0] nextFrm;

  always_comb begin
    lastFrm = (frmIdx == frameCount(patIdx) - FRM_W'(1));
    nextPat = lastFrm ? patIdx + PAT_W'(1) : patIdx;
    nextFrm = lastFrm ? '0 : frmIdx + FRM_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lamps  <= '0;
      patIdx <= '0;
      frmIdx <= '0;
    end else if (strb.load) begin
      lamps <= frameBits(patIdx, frmIdx);
    end else if (strb.step) begin
      patIdx <= nextPat;
      frmIdx <= nextFrm;
      lamps  <= frameBits(nextPat, nextFrm);
    end
  end
endmodule

// File: rtl/lamp_seq.sv
module lamp_seq
  import lamp_seq_pkg::*;
#(
  parameter int CYC_PER_SEC = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dwellSel,
  output logic [7:0] lamps,
  output logic [1:0] patIdx,
  output logic [4:0] frmIdx
);
  seqStrobe_t strb;

  lamp_seq_ctrl #(.CYC_PER_SEC(CYC_PER_SEC)) ctrl_i (
    .clk(clk), .rst(rst), .dwellSel(dwellSel), .strb(strb)
  );

  lamp_seq_path path_i (
    .clk(clk), .rst(rst), .strb(strb),
    .lamps(lamps), .patIdx(patIdx), .frmIdx(frmIdx)
  );
endmodule

// File: rtl/lamp_seq_chk.sv
module lamp_seq_chk #(
  parameter int CYC_PER_SEC = 500
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] lamps,
  input logic [1:0] patIdx,
  input logic [4:0] frmIdx
);
  localparam int HW = $clog2(4 * CYC_PER_SEC + 2);

  logic [7:0]    prevLamps;
  logic [HW-1:0] holdCnt;
  logic          seen;
  logic          changed;

  assign changed = (lamps != prevLamps);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLamps <= lamps;
      holdCnt   <= '0;
      seen      <= 1'b0;
    end else begin
      prevLamps <= lamps;
      seen      <= seen | (lamps != 8'h00);
      if (changed) holdCnt <= HW'(1);
      else if (holdCnt != '1) holdCnt <= holdCnt + HW'(1);
    end
  end

  // R1
  reset_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (lamps == 8'h00 && patIdx == 2'd0 && frmIdx == 5'd0));

  // R7
  pattern_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (patIdx != $past(patIdx)) |-> (frmIdx == 5'd0 && patIdx == $past(patIdx) + 2'd1));

  // R10
  frame_step_chk: assert property (@(posedge clk) disable iff (rst)
    (frmIdx != $past(frmIdx)) |-> (frmIdx == 5'd0 || frmIdx == $past(frmIdx) + 5'd1));

  // R10
  frame_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (patIdx == 2'd0 && frmIdx <= 5'd16) || (patIdx == 2'd1 && frmIdx <= 5'd6) ||
    (patIdx == 2'd2 && frmIdx <= 5'd4)  || (patIdx == 2'd3 && frmIdx <= 5'd3));

  // R8
  dwell_range_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && changed) |-> (holdCnt >= HW'(CYC_PER_SEC) && holdCnt <= HW'(4 * CYC_PER_SEC)));
endmodule

bind lamp_seq lamp_seq_chk #(.CYC_PER_SEC(CYC_PER_SEC)) chk_i (
  .clk(clk), .rst(rst), .lamps(lamps), .patIdx(patIdx), .frmIdx(frmIdx)
);

// File: tb/lamp_seq_tb_top.sv
`timescale 1ns/1ps
module lamp_seq_tb_top;
  localparam int CPS = 3;
  localparam int NVEC = 33;
  // {patIdx, frmIdx, lamps}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd0, 5'd0,  8'h01}, {2'd0, 5'd1,  8'h02}, {2'd0, 5'd2,  8'h04},
    {2'd0, 5'd3,  8'h08}, {2'd0, 5'd4,  8'h10}, {2'd0, 5'd5,  8'h20},
    {2'd0, 5'd6,  8'h40}, {2'd0, 5'd7,  8'h80}, {2'd0, 5'd8,  8'h40},
    {2'd0, 5'd9,  8'h20}, {2'd0, 5'd10, 8'h10}, {2'd0, 5'd11, 8'h08},
    {2'd0, 5'd12, 8'h04}, {2'd0, 5'd13, 8'h02}, {2'd0, 5'd14, 8'h01},
    {2'd0, 5'd15, 8'h00}, {2'd0, 5'd16, 8'hFF},
    {2'd1, 5'd0,  8'h81}, {2'd1, 5'd1,  8'h42}, {2'd1, 5'd2,  8'h24},
    {2'd1, 5'd3,  8'h18}, {2'd1, 5'd4,  8'h24}, {2'd1, 5'd5,  8'h42},
    {2'd1, 5'd6,  8'h81},
    {2'd2, 5'd0,  8'hC3}, {2'd2, 5'd1,  8'h66}, {2'd2, 5'd2,  8'h3C},
    {2'd2, 5'd3,  8'h66}, {2'd2, 5'd4,  8'hC3},
    {2'd3, 5'd0,  8'hE7}, {2'd3, 5'd1,  8'hF0}, {2'd3, 5'd2,  8'h0F},
    {2'd3, 5'd3,  8'h55}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] dwellSel = 2'd0;
  logic [7:0] lamps;
  logic [1:0] patIdx;
  logic [4:0] frmIdx;
  int         nChk = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  lamp_seq #(.CYC_PER_SEC(CPS)) dut_i (
    .clk(clk), .rst(rst), .dwellSel(dwellSel),
    .lamps(lamps), .patIdx(patIdx), .frmIdx(frmIdx)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string showTag(input logic [1:0] p);
    case (p)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  // cycles until lamps change, starting at the first sample of a frame
  task automatic measure(output int n, input bit doChange, input logic [1:0] newSel);
    logic [7:0] start;
    start = lamps;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (doChange && n == 1) dwellSel = newSel;
    end while (lamps == start && n < 100);
  endtask

  task automatic restart(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1;
    dwellSel = sel;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1 lamps", lamps, 8'h00);
    check("R1 patIdx", patIdx, 0);
    check("R1 frmIdx", frmIdx, 0);
    rst = 1'b0;
    @(negedge clk);
    // R2: first frame after reset
    check("R2 lamps", lamps, 8'h01);
    // full rotation, one second (3 cycles) per frame
    for (int i = 0; i < NVEC; i++) begin
      check(showTag(VEC[i][14:13]), lamps, VEC[i][7:0]);
      check("R10 patIdx", patIdx, VEC[i][14:13]);
      check("R10 frmIdx", frmIdx, VEC[i][12:8]);
      repeat (CPS) @(negedge clk);
    end
    // R7: wrap back to show 0 frame 0
    check("R7 lamps", lamps, 8'h01);
    check("R7 patIdx", patIdx, 0);
    check("R7 frmIdx", frmIdx, 0);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run lamps", lamps, 8'h00);
    check("R1 mid-run frmIdx", frmIdx, 0);

    // R8: each hold time
    for (int s = 0; s < 4; s++) begin
      restart(2'(s));
      measure(n, 1'b0, 2'd0);
      check("R8 hold", n, CPS * (s + 1));
      measure(n, 1'b0, 2'd0);
      check("R8 hold second frame", n, CPS * (s + 1));
    end

    // R9: change mid-frame applies from next frame
    restart(2'd0);
    measure(n, 1'b1, 2'd3);
    check("R9 current frame", n, CPS);
    measure(n, 1'b0, 2'd0);
    check("R9 next frame", n, 4 * CPS);
    restart(2'd3);
    measure(n, 1'b1, 2'd1);
    check("R9 current frame long", n, 4 * CPS);
    measure(n, 1'b0, 2'd0);
    check("R9 next frame short", n, 2 * CPS);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule